// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Timing Generator

This block produces the timing strobes for a serial communications interface. Software programs an 8-bit rate register. That register holds a 2-bit prescaler code, a 3-bit power-of-two rate exponent and three test-mode bits that are stored but have no effect. The block divides the core clock down to a one-cycle bit strobe. A second counter groups bit strobes into character frames of 10 or 11 bit times and emits a one-cycle frame strobe on the last bit of each frame.

Three byte registers sit behind a small synchronous register bus: the rate register, a format register that holds the character-length bit, and an enable register that holds the transmit and receive enables. The counters run only while at least one enable is set. They are cleared whenever the rate register is written, so a new rate takes effect from a clean start. On reset all three registers go to zero. When the bootstrap strap pattern is present during reset, they take instead the preset that the boot firmware expects.

Top module: `serial_baud_gen`

## Requirements
- R1: The bit period in core-clock cycles is CLK_DIV × OVS × P × 2^E. P is chosen by rate-register bits [5:4]: code 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13. With the defaults CLK_DIV=4 and OVS=16.
- R2: E is rate-register bits [2:0], so the exponent covers 0 to 7 (factor 1 to 128).
- R3: After the clock edge that writes the rate register, the first bit strobe is high in the cycle that begins P_total edges later, and the strobes then repeat every P_total cycles.
- R4: A frame is 10 bit strobes when format-register bit 4 is 0 and 11 when it is 1. The frame strobe is high together with the bit strobe that completes the frame.
- R5: Enable-register bit 4 (transmit) or bit 1 (receive) starts the counters, and counting begins at the edge that sets the first enable. While both bits are clear, no strobes occur.
- R6: A reset without the bootstrap pattern clears the rate, format and enable registers to 0x00.
- R7: A reset with boot_special=1 and boot_mode_a=0 loads 0x33 into the rate register and 0x12 into the enable register, and clears the format register.
- R8: Rate-register bits 7, 6 and 3 are stored and read back, but they do not change the bit period.
- R9: Addresses 0, 1 and 2 read back the rate, format and enable registers. Address 3 reads 0x00, and a write to address 3 changes no register.
- R10: The baud_value output always equals the stored rate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_special | input | 1 | Special-mode strap, sampled during reset |
| boot_mode_a | input | 1 | Mode-A strap, sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 rate, 1 format, 2 enable) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| baud_value | output | 8 | Stored rate register |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| frame_tick | output | 1 | One-cycle strobe per character frame |

## Verification
The bench builds the block with CLK_DIV=1 and OVS=2. This keeps the full divider structure but shrinks the longest bit period to 3328 cycles. As a result, every prescaler code, the largest exponent and the bootstrap preset rate can be timed strobe by strobe, and 10- and 11-bit frames can be measured, all inside a short run. The first-strobe latency after a rate write and the gating by the enables are measured cycle by cycle against periods computed in the bench.

// File: rtl/sbg_pkg.sv
// Shared constants and helpers for the serial bit-rate generator.
// Assumes byte-wide registers on a 2-bit address bus.
package sbg_pkg;
    localparam int unsigned REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_RATE   = 2'd0,
        ADDR_FORMAT = 2'd1,
        ADDR_ENABLE = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    localparam int unsigned PRE_LSB      = 4;   // prescaler code bits [5:4]
    localparam int unsigned LONG_CHR_BIT = 4;   // format register
    localparam int unsigned TX_EN_BIT    = 4;   // enable register
    localparam int unsigned RX_EN_BIT    = 1;   // enable register

    localparam logic [REG_W-1:0] BOOT_RATE   = 8'h33;
    localparam logic [REG_W-1:0] BOOT_ENABLE = 8'h12;

    localparam int unsigned MAX_PRE   = 13;
    localparam int unsigned MAX_SHIFT = 128;
    localparam int unsigned SHORT_FRAME = 10;
    localparam int unsigned LONG_FRAME  = 11;

    // Map the 2-bit prescaler code to its division factor.
    function automatic int unsigned pre_factor(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 3;
            2'b10:   return 4;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/sbg_regs.sv
// Register bank: rate, format and enable bytes with reset/bootstrap preset.
// Assumes a single-cycle write strobe; reads are combinational on address.
module sbg_regs
    import sbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_special,
    input  logic             boot_mode_a,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] rate_q,
    output logic [REG_W-1:0] format_q,
    output logic [REG_W-1:0] enable_q,
    output logic             rate_wr
);
    logic boot;
    assign boot    = boot_special && !boot_mode_a;
    assign rate_wr = wr && (addr == ADDR_RATE);

    // Load reset or bootstrap preset, otherwise accept bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= boot ? BOOT_RATE : '0;
            format_q <= '0;
            enable_q <= boot ? BOOT_ENABLE : '0;
        end else if (wr) begin
            case (addr)
                ADDR_RATE:   rate_q   <= wdata;
                ADDR_FORMAT: format_q <= wdata;
                ADDR_ENABLE: enable_q <= wdata;
                default:     ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_RATE:   rdata = rate_q;
            ADDR_FORMAT: rdata = format_q;
            ADDR_ENABLE: rdata = enable_q;
            default:     rdata = '0;
        endcase
    end

    AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_NONE) |=> ($stable(rate_q) && $stable(format_q) && $stable(enable_q))); // R9
    AST_BOOT_LOAD: assert property (@(posedge clk)
        (!rst_n && boot_special && !boot_mode_a) |=> (rate_q == BOOT_RATE && enable_q == BOOT_ENABLE && format_q == '0)); // R7
    AST_PLAIN_RESET: assert property (@(posedge clk)
        (!rst_n && !(boot_special && !boot_mode_a)) |=> (rate_q == '0 && enable_q == '0 && format_q == '0)); // R6
endmodule

// File: rtl/sbg_bitdiv.sv
// Bit-period divider: counts core cycles up to CLK_DIV*OVS*P*2^E.
// Assumes restart is asserted on the cycle the rate register is written.
module sbg_bitdiv
    import sbg_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic [1:0] pre_code,
    input  logic [2:0] rate_exp,
    output logic       bit_tick
);
    localparam int unsigned MAX_PERIOD = CLK_DIV * OVS * MAX_PRE * MAX_SHIFT;
    localparam int unsigned PW = $clog2(MAX_PERIOD + 1);

    logic [PW-1:0] unit_len;
    logic [PW-1:0] period;
    logic [PW-1:0] cnt;

    // Full period from the prescaler factor and the exponent.
    always_comb begin
        unit_len = PW'(CLK_DIV * OVS * pre_factor(pre_code));
        period   = unit_len << rate_exp;
    end

    // Cycle counter, held at zero while idle or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            cnt <= '0;
        end else if (cnt == period - PW'(1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end

    assign bit_tick = active && (cnt == period - PW'(1));

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period); // R1
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0)); // R5
endmodule

// File: rtl/sbg_frame.sv
// Frame counter: groups bit strobes into 10- or 11-bit frames.
// Assumes bit_tick is a one-cycle strobe from the divider.
module sbg_frame
    import sbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic bit_tick,
    input  logic long_chr,
    output logic frame_tick
);
    logic [3:0] fcnt;
    logic [3:0] last_bit;

    assign last_bit   = long_chr ? 4'(LONG_FRAME - 1) : 4'(SHORT_FRAME - 1);
    assign frame_tick = bit_tick && (fcnt >= last_bit);

    // Count bit strobes within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            fcnt <= '0;
        end else if (bit_tick) begin
            fcnt <= (fcnt >= last_bit) ? '0 : fcnt + 4'd1;
        end
    end

    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= 4'(LONG_FRAME - 1)); // R4
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && !bit_tick) |=> $stable(fcnt)); // R4
endmodule

// File: rtl/serial_baud_gen.sv
// Top level of the serial bit-rate and frame timing generator.
// Assumes synchronous active-low reset and bootstrap straps valid during reset.
module serial_baud_gen
    import sbg_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_special,
    input  logic       boot_mode_a,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] baud_value,
    output logic       bit_tick,
    output logic       frame_tick
);
    logic [REG_W-1:0] rate_q;
    logic [REG_W-1:0] format_q;
    logic [REG_W-1:0] enable_q;
    logic             rate_wr;
    logic             active;

    sbg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_special (boot_special),
        .boot_mode_a  (boot_mode_a),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .rate_q       (rate_q),
        .format_q     (format_q),
        .enable_q     (enable_q),
        .rate_wr      (rate_wr)
    );

    assign active     = enable_q[TX_EN_BIT] || enable_q[RX_EN_BIT];
    assign baud_value = rate_q;

    sbg_bitdiv #(.CLK_DIV(CLK_DIV), .OVS(OVS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .restart  (rate_wr),
        .pre_code (rate_q[PRE_LSB +: 2]),
        .rate_exp (rate_q[2:0]),
        .bit_tick (bit_tick)
    );

    sbg_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .restart    (rate_wr),
        .bit_tick   (bit_tick),
        .long_chr   (format_q[LONG_CHR_BIT]),
        .frame_tick (frame_tick)
    );

    AST_FRAME_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> bit_tick); // R4
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(bit_tick || frame_tick)); // R5
endmodule

// File: tb/test_serial_baud_gen.sv
module test_serial_baud_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BCD = 1;
    localparam int BOS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_special = 1'b0;
    logic       boot_mode_a = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] baud_value;
    logic       bit_tick;
    logic       frame_tick;

    int checks = 0;
    int failures = 0;

    serial_baud_gen #(.CLK_DIV(BCD), .OVS(BOS)) i_serial_baud_gen (
        .clk(clk), .rst_n(rst_n), .boot_special(boot_special), .boot_mode_a(boot_mode_a),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .baud_value(baud_value), .bit_tick(bit_tick), .frame_tick(frame_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic int exp_period(input logic [7:0] r);
        int p;
        case (r[5:4])
            2'b00: p = 1;
            2'b01: p = 3;
            2'b10: p = 4;
            default: p = 13;
        endcase
        return BCD * BOS * p * (1 << r[2:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sp, input logic ma);
        @(negedge clk);
        rst_n = 1'b0; boot_special = sp; boot_mode_a = ma;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Cycles from the current (first) cycle after a write until a bit strobe.
    task automatic first_tick(output int n);
        n = 1;
        while (!bit_tick && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 100000);
    endtask

    task automatic t_plain_reset;
        logic [7:0] d;
        int seen;
        do_reset(1'b0, 1'b0);
        rd(2'd0, d); check("R6 rate", d, 0);
        rd(2'd1, d); check("R6 format", d, 0);
        rd(2'd2, d); check("R6 enable", d, 0);
        check("R10 reset", baud_value, 0);
        seen = 0;
        wr(2'd0, 8'h00);
        repeat (40) begin
            @(negedge clk);
            if (bit_tick || frame_tick) seen++;
        end
        check("R5 idle no strobes", seen, 0);
    endtask

    task automatic t_rate(input logic [7:0] r);
        int n;
        logic [7:0] d;
        wr(2'd0, r);
        first_tick(n);
        check("R3 first strobe", n, exp_period(r));
        next_tick(n);
        check("R1 R2 spacing", n, exp_period(r));
        rd(2'd0, d);
        check("R9 rate readback", d, r);
        check("R10 baud_value", baud_value, r);
    endtask

    task automatic t_rates;
        wr(2'd2, 8'h02);
        t_rate(8'h00);
        t_rate(8'h10);
        t_rate(8'h20);
        t_rate(8'h30);
        t_rate(8'h07);
        t_rate(8'h35);
        t_rate(8'h37);
    endtask

    task automatic t_test_bits;
        int n;
        wr(2'd0, 8'hC9);
        first_tick(n);
        check("R8 test bits ignored", n, exp_period(8'h01));
        check("R8 test bits stored", baud_value, 8'hC9);
    endtask

    task automatic t_frame(input logic lng);
        int nb;
        int cyc;
        int want;
        want = lng ? 11 : 10;
        wr(2'd0, 8'h01);
        wr(2'd1, lng ? 8'h10 : 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h10);
        nb = 0; cyc = 1;
        while (cyc < 1000) begin
            if (bit_tick) nb++;
            if (frame_tick) break;
            @(negedge clk);
            cyc++;
        end
        check("R4 bits per frame", nb, want);
        check("R4 R5 frame cycles", cyc, want * 4);
        nb = 0;
        do begin
            @(negedge clk);
            if (bit_tick) nb++;
        end while (!frame_tick && nb < 20);
        check("R4 second frame", nb, want);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        wr(2'd0, 8'h25);
        wr(2'd3, 8'hFF);
        rd(2'd0, d); check("R9 rate kept", d, 8'h25);
        rd(2'd1, d); check("R9 format kept", d, 8'h10);
        rd(2'd2, d); check("R9 enable kept", d, 8'h10);
        rd(2'd3, d); check("R9 addr3 reads zero", d, 0);
    endtask

    task automatic t_boot;
        logic [7:0] d;
        int n;
        do_reset(1'b1, 1'b0);
        rd(2'd0, d); check("R7 boot rate", d, 8'h33);
        rd(2'd1, d); check("R7 boot format", d, 0);
        rd(2'd2, d); check("R7 boot enable", d, 8'h12);
        first_tick(n);
        next_tick(n);
        check("R7 boot spacing", n, exp_period(8'h33));
        do_reset(1'b1, 1'b1);
        rd(2'd0, d); check("R6 mode_a rate", d, 0);
        rd(2'd2, d); check("R6 mode_a enable", d, 0);
    endtask

    initial begin
        t_plain_reset();
        t_rates();
        t_test_bits();
        t_frame(1'b0);
        t_frame(1'b1);
        t_unused();
        t_boot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule